// File: doc/BRIEF.md
# Raster Timing Generator with Vertical-Blank Interrupt

This block is the beam-position timer of a tile-based video unit. On every clock cycle where its advance strobe is high it steps a dot counter across a scanline. At the end of each line it steps a line counter, and at the end of each frame it steps a 32-bit frame counter. From these counters it derives the vertical-blank state. It also produces a one-cycle end-of-frame strobe and a one-cycle interrupt request toward the processor. The request is raised only when the processor has enabled it.

The processor reaches the block through a small byte-wide port. It writes an enable byte at one address. It reads two status bytes: one shows the vertical-blank state alone, and the other shows the vertical-blank and horizontal-blank windows together. Reads decode combinationally from the address and the current counters. Every address the block does not serve reads as zero.

Top module: `raster_timer`

## Requirements
- R1: After reset, the dot, line and frame counters are 0, vertical blank is 0, the interrupt enable is 0, and both the interrupt request and the end-of-frame strobe are low.
- R2: The dot counter advances by one on each clock where `tick` is 1. When it passes 340 it returns to 0 and the line counter increments. When `tick` is 0, the dot, line and frame counters all hold.
- R3: On the tick that takes the line counter from 224 to 225, vertical blank becomes 1 and `frame_end` pulses high for exactly one clock, in the same cycle the line counter shows 225.
- R4: On that same tick, `nmi_req` pulses high for exactly one clock, but only if the interrupt enable is 1. The enable is bit 7 of a write to address 0x4200. Setting the enable later during the same vertical blank raises no request.
- R5: On the tick that would take the line counter to 260, the line counter returns to 0, vertical blank clears and the frame counter increments by one.
- R6: A read of address 0x4210 returns 0x80 while vertical blank is 1, and 0x00 otherwise.
- R7: A read of address 0x4212 has bit 7 set when the line counter is 225 or more. It has bit 6 set when the dot counter is at least 0x121 or at most 0x15. Both bits may be 1 together, and bits 5 to 0 read as 0.
- R8: A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Dot advance enable |
| cpu_addr | input | 16 | Processor port address |
| cpu_we | input | 1 | Write strobe for the processor port |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, decoded from `cpu_addr` |
| dot | output | 9 | Current dot within the line |
| line | output | 9 | Current scanline |
| frame | output | 32 | Frame counter |
| vblank | output | 1 | Vertical-blank state |
| frame_end | output | 1 | One-clock strobe on entry to vertical blank |
| nmi_req | output | 1 | One-clock interrupt request on entry to vertical blank |

## Verification
A wrong dot count shows up within a line as a shifted horizontal-blank bit in the second status byte, so the bench probes both edges of that window. A wrong line count or a wrong vertical-blank register shows as an interrupt pulse or status bit that moves by whole lines, or as a late or missing frame increment. The bench therefore checks the cycles just before and just after lines 225 and 260. An enable that leaks into a running vertical blank, or that is ignored, shows as an extra or missing interrupt pulse. These pulses are counted over two frames, with the enable both set and cleared.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam logic [15:0] ADDR_NMI_CTRL = 16'h4200;
  localparam logic [15:0] ADDR_VB_STAT  = 16'h4210;
  localparam logic [15:0] ADDR_HV_STAT  = 16'h4212;
  localparam int NMI_EN_BIT  = 7;
  localparam int VB_FLAG_BIT = 7;
  localparam int HB_FLAG_BIT = 6;
endpackage

// File: rtl/raster_rst_sync.sv
module raster_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int DOT_LAST   = 340,
  parameter int LINE_COUNT = 260,
  parameter int VB_LINE    = 225,
  parameter int FRAME_W    = 32,
  localparam int DOT_W  = $clog2(DOT_LAST + 1),
  localparam int LINE_W = $clog2(LINE_COUNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  output logic [DOT_W-1:0]   dot,
  output logic [LINE_W-1:0]  line,
  output logic [FRAME_W-1:0] frame,
  output logic               enter_vb,
  output logic               frame_wrap
);
  localparam logic [DOT_W-1:0]  DOT_MAX   = DOT_W'(DOT_LAST);
  localparam logic [LINE_W-1:0] LINE_MAX  = LINE_W'(LINE_COUNT - 1);
  localparam logic [LINE_W-1:0] LINE_PRE  = LINE_W'(VB_LINE - 1);

  logic [DOT_W-1:0]   dot_d;
  logic [LINE_W-1:0]  line_d;
  logic [FRAME_W-1:0] frame_d;
  logic               line_end;

  always_comb begin
    line_end   = tick && (dot == DOT_MAX);
    enter_vb   = line_end && (line == LINE_PRE);
    frame_wrap = line_end && (line == LINE_MAX);
    dot_d   = dot;
    line_d  = line;
    frame_d = frame;
    if (tick) begin
      if (line_end) begin
        dot_d = '0;
        if (frame_wrap) begin
          line_d  = '0;
          frame_d = frame + 1'b1;
        end else begin
          line_d = line + 1'b1;
        end
      end else begin
        dot_d = dot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot   <= '0;
      line  <= '0;
      frame <= '0;
    end else begin
      dot   <= dot_d;
      line  <= line_d;
      frame <= frame_d;
    end
  end

  assert_dot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dot <= DOT_MAX);

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(dot) && $stable(line) && $stable(frame)));

  assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dot == DOT_MAX && line != LINE_MAX) |=> (dot == '0 && line == $past(line) + 1'b1));

  assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dot == DOT_MAX && line == LINE_MAX) |=> (line == '0 && frame == $past(frame) + 1'b1));
endmodule

// File: rtl/raster_vblank_ctrl.sv
module raster_vblank_ctrl #(
  parameter int VB_LINE = 225,
  parameter int LINE_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_vb,
  input  logic              frame_wrap,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [LINE_W-1:0] line,
  output logic              vblank,
  output logic              frame_end,
  output logic              nmi_req
);
  import raster_pkg::*;

  logic nmi_en, nmi_en_d;
  logic vblank_d, frame_end_d, nmi_req_d;

  always_comb begin
    nmi_en_d = nmi_en;
    if (cpu_we && cpu_addr == ADDR_NMI_CTRL) nmi_en_d = cpu_wdata[NMI_EN_BIT];
    vblank_d = vblank;
    if (enter_vb)        vblank_d = 1'b1;
    else if (frame_wrap) vblank_d = 1'b0;
    frame_end_d = enter_vb;
    nmi_req_d   = enter_vb && nmi_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_en    <= 1'b0;
      vblank    <= 1'b0;
      frame_end <= 1'b0;
      nmi_req   <= 1'b0;
    end else begin
      nmi_en    <= nmi_en_d;
      vblank    <= vblank_d;
      frame_end <= frame_end_d;
      nmi_req   <= nmi_req_d;
    end
  end

  assert_vblank_tracks_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vblank == (line >= LINE_W'(VB_LINE)));

  assert_frame_end_at_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (vblank && line == LINE_W'(VB_LINE)));

  assert_nmi_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  assert_nmi_with_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> frame_end);
endmodule

// File: rtl/raster_status_port.sv
module raster_status_port #(
  parameter int DOT_W   = 9,
  parameter int LINE_W  = 9,
  parameter int VB_LINE = 225,
  parameter int HB_LOW  = 'h15,
  parameter int HB_HIGH = 'h121
) (
  input  logic [15:0]       cpu_addr,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              vblank,
  output logic [7:0]        cpu_rdata
);
  import raster_pkg::*;

  logic in_hblank, in_vb_lines;

  always_comb begin
    in_hblank   = (dot >= DOT_W'(HB_HIGH)) || (dot <= DOT_W'(HB_LOW));
    in_vb_lines = (line >= LINE_W'(VB_LINE));
    cpu_rdata   = 8'h00;
    unique case (cpu_addr)
      ADDR_VB_STAT: cpu_rdata[VB_FLAG_BIT] = vblank;
      ADDR_HV_STAT: begin
        cpu_rdata[VB_FLAG_BIT] = in_vb_lines;
        cpu_rdata[HB_FLAG_BIT] = in_hblank;
      end
      default: cpu_rdata = 8'h00;
    endcase
  end

  always_comb begin
    if (cpu_addr != ADDR_VB_STAT && cpu_addr != ADDR_HV_STAT)
      assert_unserved_zero_R8: assert (cpu_rdata == 8'h00);
  end
endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int DOT_LAST   = 340,
  parameter int LINE_COUNT = 260,
  parameter int VB_LINE    = 225,
  parameter int HB_LOW     = 'h15,
  parameter int HB_HIGH    = 'h121,
  parameter int FRAME_W    = 32,
  localparam int DOT_W  = $clog2(DOT_LAST + 1),
  localparam int LINE_W = $clog2(LINE_COUNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_we,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic [DOT_W-1:0]   dot,
  output logic [LINE_W-1:0]  line,
  output logic [FRAME_W-1:0] frame,
  output logic               vblank,
  output logic               frame_end,
  output logic               nmi_req
);
  logic rst_n_sync;
  logic enter_vb, frame_wrap;

  raster_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  raster_counters #(
    .DOT_LAST(DOT_LAST), .LINE_COUNT(LINE_COUNT), .VB_LINE(VB_LINE), .FRAME_W(FRAME_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick),
    .dot(dot), .line(line), .frame(frame),
    .enter_vb(enter_vb), .frame_wrap(frame_wrap)
  );

  raster_vblank_ctrl #(.VB_LINE(VB_LINE), .LINE_W(LINE_W)) u_vb (
    .clk(clk), .rst_n(rst_n_sync),
    .enter_vb(enter_vb), .frame_wrap(frame_wrap),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .line(line), .vblank(vblank), .frame_end(frame_end), .nmi_req(nmi_req)
  );

  raster_status_port #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .VB_LINE(VB_LINE), .HB_LOW(HB_LOW), .HB_HIGH(HB_HIGH)
  ) u_stat (
    .cpu_addr(cpu_addr), .dot(dot), .line(line), .vblank(vblank), .cpu_rdata(cpu_rdata)
  );
endmodule

// File: tb/test_raster_timer.sv
module test_raster_timer;
  localparam int DOTS  = 341;
  localparam int LINES = 260;
  localparam int FRAME_TICKS = DOTS * LINES;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [8:0]  dot, line;
  logic [31:0] frame;
  logic        vblank, frame_end, nmi_req;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int nmi_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  raster_timer i_raster_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dot(dot), .line(line), .frame(frame),
    .vblank(vblank), .frame_end(frame_end), .nmi_req(nmi_req)
  );

  always @(negedge clk) if (rst_n && nmi_req) nmi_seen++;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic advance(int k);
    if (k > 0) begin
      tick = 1'b1;
      repeat (k) @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
      n += k;
    end
  endtask

  task automatic goto_tick(int target);
    advance(target - n);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  function automatic logic [7:0] rd(logic [15:0] a);
    cpu_addr = a;
    return 8'h00;
  endfunction

  task automatic read_chk(string req, logic [15:0] a, logic [7:0] exp);
    cpu_addr = a;
    #1;
    chk(req, $sformatf("read %h", a), cpu_rdata, exp);
  endtask

  task automatic pos_chk(string req);
    int d = n % DOTS;
    int l = (n / DOTS) % LINES;
    logic [7:0] hv;
    hv = {l >= 225, (d >= 'h121 || d <= 'h15), 6'b0};
    chk(req, "dot", dot, d);
    chk(req, "line", line, l);
    chk(req, "frame", frame, n / FRAME_TICKS);
    read_chk(req, 16'h4212, hv);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "dot", dot, 0);
    chk("R1", "line", line, 0);
    chk("R1", "frame", frame, 0);
    chk("R1", "vblank", vblank, 0);
    chk("R1", "nmi_req", nmi_req, 0);
    chk("R1", "frame_end", frame_end, 0);
    read_chk("R1", 16'h4210, 8'h00);
  endtask

  task automatic t_dot_walk;
    advance(1);   pos_chk("R2");
    goto_tick(21);  pos_chk("R7");
    goto_tick(22);  pos_chk("R7");
    goto_tick(288); pos_chk("R7");
    goto_tick(289); pos_chk("R7");
    goto_tick(340); pos_chk("R2");
    goto_tick(341); pos_chk("R2");
    repeat (5) @(negedge clk);
    pos_chk("R2");
  endtask

  task automatic t_unserved;
    read_chk("R8", 16'h4211, 8'h00);
    read_chk("R8", 16'h2000, 8'h00);
    read_chk("R8", 16'h4200, 8'h00);
  endtask

  task automatic t_enter_vblank;
    goto_tick(225 * DOTS - 1);
    chk("R3", "vblank before", vblank, 0);
    chk("R4", "nmi count before", nmi_seen, 0);
    advance(1);
    chk("R3", "line", line, 225);
    chk("R3", "vblank", vblank, 1);
    chk("R3", "frame_end", frame_end, 1);
    chk("R4", "nmi_req", nmi_req, 1);
    read_chk("R6", 16'h4210, 8'h80);
    read_chk("R7", 16'h4212, 8'hC0);
    @(negedge clk);
    chk("R3", "frame_end width", frame_end, 0);
    chk("R4", "nmi_req width", nmi_req, 0);
    wr(16'h4200, 8'h80);
    advance(DOTS);
    chk("R4", "no request on late enable", nmi_seen, 1);
  endtask

  task automatic t_frame_wrap;
    goto_tick(FRAME_TICKS - 1);
    chk("R5", "line before wrap", line, 259);
    chk("R5", "vblank before wrap", vblank, 1);
    advance(1);
    chk("R5", "line", line, 0);
    chk("R5", "dot", dot, 0);
    chk("R5", "frame", frame, 1);
    chk("R5", "vblank", vblank, 0);
    read_chk("R6", 16'h4210, 8'h00);
  endtask

  task automatic t_masked;
    wr(16'h4200, 8'h7F);
    goto_tick(FRAME_TICKS + 225 * DOTS);
    chk("R4", "masked entry vblank", vblank, 1);
    chk("R4", "masked no request", nmi_seen, 1);
    wr(16'h4200, 8'h80);
    advance(100);
    chk("R4", "late enable no request", nmi_seen, 1);
    pos_chk("R7");
  endtask

  initial begin
    t_reset();
    wr(16'h4200, 8'h80);
    t_dot_walk();
    t_unserved();
    t_enter_vblank();
    t_frame_wrap();
    t_masked();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule